// File: doc/BRIEF.md
# Programmable Round and Saturate Stage

This stage sits at the end of a fixed-point filter datapath. It accepts the wide signed accumulator sum, whose low `FRAC_W` bits lie below the output LSB, and reduces it to a 16-bit output word. Software or pin strapping picks the resolution at run time. The result carries from 9 to 16 significant bits. The stage adds half an LSB at the selected position and clears every bit beneath it.

After rounding, the value is clamped to a full-scale window. That window narrows by half when the upstream filter runs in its minus-6-dB interpolating gain mode. The clamped two's-complement word then leaves either unchanged or as inverted offset binary. The result passes through a single output register, and a valid strobe travels alongside it.

Top module: `round_sat_stage`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-low reset drives `out_valid` and `out_data` to 0.
- R2: `out_data` changes only in the cycle after `in_valid` was high, and holds its value in every other cycle.
- R3: The input has `FRAC_W` (default 6) fraction bits below the output LSB. With `res_sel`=0, `fmt_twos`=1 and no overflow, `out_data` equals the rounded value of `in_acc / 2^FRAC_W`.
- R4: `res_sel` value k (0..7) keeps 16-k significant bits. In an unsaturated result, `out_data` bits [k-1:0] are zero, so 0 selects 16 bits and 7 selects 9 bits.
- R5: Rounding adds 2^(FRAC_W+k-1) to the input and then discards everything below weight 2^(FRAC_W+k). An exact half therefore rounds toward positive infinity.
- R6: With `half_gain`=0, a rounded result above 32767 gives 16'h7FFF. This includes a round-up that crosses full scale.
- R7: With `half_gain`=0, a rounded result below -32768 gives 16'h8000.
- R8: With `half_gain`=1, the limits are 16'h3FFF and 16'hC000 (two's complement), and in-range results are unaffected.
- R9: `fmt_twos`=1 outputs the clamped two's-complement word. `fmt_twos`=0 outputs inverted offset binary: the MSB is flipped and then every bit is inverted, which equals the word XOR 16'h7FFF. For example, 16'h7FFF becomes 16'h0000 and 16'h8000 becomes 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_acc | input | ACC_W (24) | Signed accumulator value |
| res_sel | input | 3 | Resolution select, k = bits dropped |
| fmt_twos | input | 1 | 1: two's complement, 0: inverted offset binary |
| half_gain | input | 1 | 1: minus-6-dB gain mode limits |
| out_data | output | 16 | Registered output word |
| out_valid | output | 1 | Output strobe |

## Verification
The assertions check, on every cycle, the one-cycle alignment of `out_valid` and the hold of `out_data` between strobes. They also check that the clamped word stays inside the half-gain window and that bits below the chosen LSB are clear whenever the word is not a limit code. Only the bench scenarios can show the numeric correctness of rounding, including ties, negative values and the round-up that crosses full scale. The same holds for the exact limit codes and the code conversion for the inverted offset-binary format.

// File: rtl/rs_pkg.sv
// Package: shared defaults and limit helpers for the round/saturate stage.
// Assumes the output word is at most 32 bits wide.
package rs_pkg;
    localparam int DEF_ACC_W  = 24;
    localparam int DEF_OUT_W  = 16;
    localparam int DEF_FRAC_W = 6;
    localparam int RES_W      = 3;

    // Largest positive code for an output of out_w bits, halved when half is set.
    function automatic longint pos_limit(input int out_w, input bit half);
        pos_limit = half ? ((longint'(1) << (out_w - 2)) - 1)
                         : ((longint'(1) << (out_w - 1)) - 1);
    endfunction
endpackage

// File: rtl/rs_rounder.sv
// Module: rs_rounder
// Adds half an LSB at the selected resolution, drops the fraction bits and
// clears the result bits below the selected LSB. Output is in output-LSB units.
// Assumes FRAC_W >= 1 and FRAC_W + 2^RES_W - 1 < ACC_W.
module rs_rounder #(
    parameter int ACC_W  = rs_pkg::DEF_ACC_W,
    parameter int FRAC_W = rs_pkg::DEF_FRAC_W,
    parameter int RES_W  = rs_pkg::RES_W,
    localparam int SUM_W = ACC_W + 1,
    localparam int SCL_W = SUM_W - FRAC_W,
    localparam int SH_W  = $clog2(SUM_W + 1)
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [RES_W-1:0]        res,
    output logic signed [SCL_W-1:0] rounded
);
    logic [SH_W-1:0]         shift;
    logic signed [SUM_W-1:0] ext;
    logic signed [SUM_W-1:0] half_lsb;
    logic signed [SUM_W-1:0] sum;
    logic [SCL_W-1:0]        keep;
    logic                    unused_low;

    // Form the rounding constant and the one-bit-wider sum.
    always_comb begin
        shift    = SH_W'(FRAC_W) + SH_W'(res);
        ext      = {acc[ACC_W-1], acc};
        half_lsb = SUM_W'(1) << (shift - SH_W'(1));
        sum      = ext + half_lsb;
    end

    // One mask bit per scaled position: keep only bits at or above the LSB.
    for (genvar j = 0; j < SCL_W; j++) begin : g_keep
        assign keep[j] = (32'(j) >= 32'(res));
    end

    // Drop fraction bits and clear sub-LSB bits.
    always_comb begin
        rounded = sum[SUM_W-1:FRAC_W] & keep;
    end

    assign unused_low = ^sum[FRAC_W-1:0];
endmodule

// File: rtl/rs_limiter.sv
// Module: rs_limiter
// Clamps the rounded value to the full-scale window of the output word,
// narrowed by half in the reduced-gain mode. Assumes IN_W > OUT_W.
module rs_limiter #(
    parameter int IN_W  = 19,
    parameter int OUT_W = rs_pkg::DEF_OUT_W
) (
    input  logic signed [IN_W-1:0] val,
    input  logic                   half,
    output logic [OUT_W-1:0]       word
);
    localparam logic signed [IN_W-1:0] HI_FULL = IN_W'(rs_pkg::pos_limit(OUT_W, 1'b0));
    localparam logic signed [IN_W-1:0] HI_HALF = IN_W'(rs_pkg::pos_limit(OUT_W, 1'b1));
    localparam logic signed [IN_W-1:0] LO_FULL = -HI_FULL - IN_W'(1);
    localparam logic signed [IN_W-1:0] LO_HALF = -HI_HALF - IN_W'(1);

    logic signed [IN_W-1:0] hi;
    logic signed [IN_W-1:0] lo;

    // Pick the window for the gain mode, then clamp.
    always_comb begin
        hi = half ? HI_HALF : HI_FULL;
        lo = half ? LO_HALF : LO_FULL;
        if (val > hi)      word = hi[OUT_W-1:0];
        else if (val < lo) word = lo[OUT_W-1:0];
        else               word = val[OUT_W-1:0];
    end
endmodule

// File: rtl/rs_formatter.sv
// Module: rs_formatter
// Passes the clamped two's-complement word, or recodes it as inverted
// offset binary (flip MSB, then invert all bits).
module rs_formatter #(
    parameter int W = rs_pkg::DEF_OUT_W
) (
    input  logic [W-1:0] word,
    input  logic         twos,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] MSB_BIT = W'(1) << (W - 1);

    // Select output code.
    always_comb begin
        code = twos ? word : ~(word ^ MSB_BIT);
    end
endmodule

// File: rtl/round_sat_stage.sv
// Module: round_sat_stage (top)
// Rounds a wide signed accumulator to a selectable resolution, clamps it,
// converts the code format and registers the word with a valid strobe.
// Assumes inputs are synchronous to clk; one cycle of latency.
module round_sat_stage #(
    parameter int ACC_W  = rs_pkg::DEF_ACC_W,
    parameter int OUT_W  = rs_pkg::DEF_OUT_W,
    parameter int FRAC_W = rs_pkg::DEF_FRAC_W,
    localparam int RES_W = rs_pkg::RES_W,
    localparam int SCL_W = ACC_W + 1 - FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [ACC_W-1:0] in_acc,
    input  logic [RES_W-1:0]        res_sel,
    input  logic                    fmt_twos,
    input  logic                    half_gain,
    output logic [OUT_W-1:0]        out_data,
    output logic                    out_valid
);
    logic signed [SCL_W-1:0] rnd_val;
    logic [OUT_W-1:0]        sat_word;
    logic [OUT_W-1:0]        fmt_word;

    rs_rounder #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_round (
        .acc(in_acc), .res(res_sel), .rounded(rnd_val));

    rs_limiter #(.IN_W(SCL_W), .OUT_W(OUT_W)) u_limit (
        .val(rnd_val), .half(half_gain), .word(sat_word));

    rs_formatter #(.W(OUT_W)) u_fmt (
        .word(sat_word), .twos(fmt_twos), .code(fmt_word));

    // Output register: capture on valid, strobe follows input valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= fmt_word;
        end
    end

    localparam logic [OUT_W-1:0] HALF_HI = OUT_W'(rs_pkg::pos_limit(OUT_W, 1'b1));
    localparam logic [OUT_W-1:0] FULL_HI = OUT_W'(rs_pkg::pos_limit(OUT_W, 1'b0));

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R8
    half_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_gain |-> ($signed(sat_word) <= $signed(HALF_HI)) &&
                      ($signed(sat_word) >= $signed(~HALF_HI)));
    // R4
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_word != FULL_HI && sat_word != ~FULL_HI &&
         sat_word != HALF_HI && sat_word != ~HALF_HI)
        |-> ((sat_word & ((OUT_W'(1) << res_sel) - OUT_W'(1))) == '0));
endmodule

// File: tb/tb_round_sat_stage.sv
module tb_round_sat_stage;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_acc = '0;
    logic [2:0]         res_sel = '0;
    logic               fmt_twos = 1'b1;
    logic               half_gain = 1'b0;
    logic [15:0]        out_data;
    logic               out_valid;
    int total = 0;
    int bad = 0;

    round_sat_stage dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
        .res_sel(res_sel), .fmt_twos(fmt_twos), .half_gain(half_gain),
        .out_data(out_data), .out_valid(out_valid));

    always #5 clk = ~clk;

    // Model from the requirements: round, floor-shift, clamp, recode.
    function automatic logic [15:0] model(input longint acc, input int k, input bit half, input bit tco);
        longint v, hi, w;
        int sh;
        sh = 6 + k;
        v  = (acc + (longint'(1) << (sh - 1))) >>> sh;
        v  = v * (longint'(1) << k);
        hi = half ? 16383 : 32767;
        if (v > hi) w = hi;
        else if (v < -hi - 1) w = -hi - 1;
        else w = v;
        model = tco ? w[15:0] : (w[15:0] ^ 16'h7FFF);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one valid sample at negedge, check the registered word one edge later.
    task automatic apply(input string req, input longint acc, input int k, input bit half,
                         input bit tco, input logic [15:0] exp);
        in_valid = 1'b1; in_acc = 24'(acc); res_sel = 3'(k);
        half_gain = half; fmt_twos = tco;
        @(negedge clk);
        check({req, " valid"}, {15'd0, out_valid}, 16'd1);
        check(req, out_data, exp);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        in_valid = 1'b1; in_acc = 24'h012345;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {15'd0, out_valid}, 16'd0);
        check("R1 reset data", out_data, 16'h0000);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {15'd0, out_valid}, 16'd0);
    endtask

    task automatic t_scale();
        apply("R3 plus one", 64, 0, 0, 1, 16'h0001);
        apply("R3 minus one", -64, 0, 0, 1, 16'hFFFF);
        apply("R3 mid", 24'h123456, 0, 0, 1, model(24'h123456, 0, 0, 1));
        apply("R3 neg mid", -24'sh0ABCDE, 0, 0, 1, model(-24'sh0ABCDE, 0, 0, 1));
        idle();
    endtask

    task automatic t_round();
        apply("R5 half up", 32, 0, 0, 1, 16'h0001);
        apply("R5 below half", 31, 0, 0, 1, 16'h0000);
        apply("R5 neg tie", -32, 0, 0, 1, 16'h0000);
        apply("R5 neg past tie", -33, 0, 0, 1, 16'hFFFF);
        apply("R5 tie k3", 256, 3, 0, 1, 16'h0008);
        idle();
    endtask

    task automatic t_res();
        for (int k = 0; k < 8; k++) begin
            apply("R4 res sweep", 24'h123456, k, 0, 1, model(24'h123456, k, 0, 1));
            check("R4 low bits zero", out_data & ((16'd1 << k) - 16'd1), 16'h0000);
        end
        idle();
    endtask

    task automatic t_sat();
        apply("R6 pos clamp", 24'h7FFFFF, 0, 0, 1, 16'h7FFF);
        apply("R6 roundup clamp", 24'h1FFFE0, 0, 0, 1, 16'h7FFF);
        apply("R6 roundup clamp k7", 24'h1FFFC0, 7, 0, 1, 16'h7FFF);
        apply("R7 neg clamp", -24'sh800000, 0, 0, 1, 16'h8000);
        apply("R7 neg clamp k5", -24'sh300000, 5, 0, 1, 16'h8000);
        idle();
    endtask

    task automatic t_half();
        apply("R8 pos half", 24'h100000, 0, 1, 1, 16'h3FFF);
        apply("R8 neg half", -24'sh100040, 0, 1, 1, 16'hC000);
        apply("R8 in range", 24'h0FFFC0, 0, 1, 1, 16'h3FFF);
        apply("R8 in range small", 24'h001000, 0, 1, 1, 16'h0040);
        apply("R8 half offset fmt", 24'h7FFFFF, 0, 1, 0, 16'h4000);
        idle();
    endtask

    task automatic t_fmt();
        apply("R9 zero", 0, 0, 0, 0, 16'h7FFF);
        apply("R9 pos fs", 24'h7FFFFF, 0, 0, 0, 16'h0000);
        apply("R9 neg fs", -24'sh800000, 0, 0, 0, 16'hFFFF);
        apply("R9 minus one", -64, 0, 0, 0, 16'h8000);
        idle();
    endtask

    task automatic t_hold();
        apply("R2 load", 24'h000140, 0, 0, 1, 16'h0005);
        in_valid = 1'b0; in_acc = 24'h3FFFFF; fmt_twos = 1'b0;
        @(negedge clk);
        check("R1 strobe low", {15'd0, out_valid}, 16'd0);
        check("R2 hold 1", out_data, 16'h0005);
        in_acc = -24'sh7FFFFF;
        @(negedge clk);
        check("R2 hold 2", out_data, 16'h0005);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_scale();
        t_round();
        t_res();
        t_sat();
        t_half();
        t_fmt();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule